// File: doc/BRIEF.md
# Programmable Flag Offset Register Unit

This unit holds the two thresholds used by a FIFO's programmable flags: the empty offset, which sets how few words count as "almost empty", and the full offset, which sets how few free locations count as "almost full". The comparison against the FIFO fill level happens in a separate block. This unit only stores, programs and reads back the two offsets.

A single access pin has two jobs. While master reset is asserted, its level picks the default threshold. The low default is 127 and the high default is 1023, and the chosen value goes into both offsets. The same level also fixes the programming method. Low selects parallel and high selects serial. After reset the pin becomes the strobe that sends write-enable and read-enable traffic to the offset registers.

In parallel mode the data bus loads the empty offset and then the full offset on successive strobed writes. In serial mode one bit is shifted in per clock whenever the serial enable is high. Read-back works in either mode and returns the offsets in the same alternating order. Partial reset keeps the offsets and the method, and only restarts the access sequences.

Top module: `flag_ofs_prog`

## Requirements
- R1: While `rst_n` is low and `ofs_access` is 0 on a clock edge, both offsets become 127 and `serial_mode` becomes 0. On that edge `rdata` also becomes 0 and `rdata_valid` becomes 0.
- R2: While `rst_n` is low and `ofs_access` is 1 on a clock edge, both offsets become 1023 truncated to AW bits and `serial_mode` becomes 1. After master reset is released, `serial_mode` changes only at the next master reset.
- R3: In parallel mode (`serial_mode`=0), an edge with `ofs_access`=1 and `wr_en`=1 loads `wdata[AW-1:0]` into one offset. The first such write after a reset goes to the empty offset, and later writes alternate between full and empty. The new value is visible after that edge.
- R4: Offsets do not change on an edge with `wr_en`=1 and `ofs_access`=0. In serial mode, strobed parallel writes do not change the offsets either.
- R5: In serial mode, each edge with `ser_en`=1 stores `ser_in` into one bit position, least-significant bit first. Edges 0 to AW-1 of a sequence fill empty-offset bits 0 to AW-1, and edges AW to 2·AW-1 fill full-offset bits 0 to AW-1. The sequence then wraps to empty-offset bit 0. Edges with `ser_en`=0 change nothing.
- R6: In parallel mode, `ser_en` and `ser_in` have no effect on the offsets.
- R7: An edge with `ofs_access`=1 and `rd_en`=1 puts one offset, zero-extended, on `rdata` and drives `rdata_valid` to 1 for that cycle. The first read after a reset returns the empty offset, and reads alternate from there. A read in the same edge as a write returns the value from before the write. On every other edge `rdata_valid` is 0 and `rdata` holds its value.
- R8: An edge with `part_rst_n`=0 (and `rst_n`=1) leaves both offsets, `serial_mode` and `rdata` unchanged and ignores all accesses. It drives `rdata_valid` to 0 and restarts the write, read and serial sequences at the empty offset, bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Master reset, active low, synchronous |
| part_rst_n | input | 1 | Partial reset, active low, synchronous |
| ofs_access | input | 1 | Selects the default and method during master reset; strobes offset accesses afterwards |
| wr_en | input | 1 | Write enable |
| rd_en | input | 1 | Read enable |
| ser_en | input | 1 | Serial shift enable |
| ser_in | input | 1 | Serial data bit |
| wdata | input | DW | Parallel write data |
| rdata | output | DW | Offset read-back data |
| rdata_valid | output | 1 | High for the cycle after an offset read |
| empty_ofs | output | AW | Empty offset value |
| full_ofs | output | AW | Full offset value |
| serial_mode | output | 1 | 1 when serial programming was selected at master reset |

## Verification
The assertions assume that every input is a clean 0 or 1 on each rising edge. They also assume that master reset is held for at least one edge before any check is armed. Several of them compare a signal with its value on the previous edge, so those checks only hold once the previous edge lay outside master reset.

The bench drives all inputs at the falling edge from a deterministic sequence, so every edge sees settled, known values. Every run starts with master reset held for two cycles. Later master resets are always at least one full cycle long and are followed by a release.

// File: rtl/flag_ofs_pkg.sv
// Package: shared types and helpers for the flag offset register unit.
// Assumes: the offset width never exceeds 32 bits.
package flag_ofs_pkg;

    // Which offset register an access sequence points at next.
    typedef enum logic {
        SEL_EMPTY = 1'b0,
        SEL_FULL  = 1'b1
    } ofs_sel_e;

    // Advance an alternating register selector.
    function automatic ofs_sel_e next_sel(input ofs_sel_e cur);
        return (cur == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
    endfunction

endpackage

// File: rtl/flag_ofs_mode.sv
// Module: flag_ofs_mode
// Latches the programming method from the access pin during master reset.
// Also supplies the default offset picked by that same pin level.
// Assumes: DEF_LO and DEF_HI are non-negative; they are truncated to AW bits.
module flag_ofs_mode #(
    parameter int AW     = 10,
    parameter int DEF_LO = 127,
    parameter int DEF_HI = 1023
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ofs_access,
    output logic          serial_mode,
    output logic [AW-1:0] dflt_ofs
);

    localparam logic [AW-1:0] LO_VAL = AW'(DEF_LO);
    localparam logic [AW-1:0] HI_VAL = AW'(DEF_HI);

    // Default value that master reset loads into both offsets.
    always_comb begin
        dflt_ofs = ofs_access ? HI_VAL : LO_VAL;
    end

    // Method latch: follows the access pin only while master reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            serial_mode <= ofs_access;
        end
    end

endmodule

// File: rtl/flag_ofs_writer.sv
// Module: flag_ofs_writer
// Stores the empty and full offsets and applies parallel or serial writes to them.
// Parallel writes alternate empty -> full. Serial writes fill the empty offset and
// then the full offset, LSB first, one bit per enabled edge.
// Assumes: DW >= AW (the upper data bits are dropped).
module flag_ofs_writer
    import flag_ofs_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          part_rst_n,
    input  logic [AW-1:0] dflt_ofs,
    input  logic          serial_mode,
    input  logic          ofs_access,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    input  logic          ser_en,
    input  logic          ser_in,
    output logic [AW-1:0] empty_ofs,
    output logic [AW-1:0] full_ofs
);

    localparam int NREG  = 2;
    localparam int NBITS = NREG * AW;
    localparam int CW    = $clog2(NBITS);
    localparam logic [CW-1:0] LAST_BIT = CW'(NBITS - 1);

    ofs_sel_e        wr_sel;
    logic [CW-1:0]   bit_cnt;
    logic            par_we;
    logic            ser_we;
    logic [AW-1:0]   wr_val;
    logic [NREG-1:0][AW-1:0] ofs_q;
    logic [NREG-1:0]         reg_par_hit;
    logic [NREG-1:0][AW-1:0] reg_bit_hit;

    // Qualified write strobes for each programming method.
    always_comb begin
        par_we = part_rst_n && !serial_mode && ofs_access && wr_en;
        ser_we = part_rst_n && serial_mode && ser_en;
        wr_val = AW'(wdata);
    end

    // Parallel-write selector: restarts at the empty offset on any reset.
    always_ff @(posedge clk) begin
        if (!rst_n || !part_rst_n) begin
            wr_sel <= SEL_EMPTY;
        end else if (par_we) begin
            wr_sel <= next_sel(wr_sel);
        end
    end

    // Serial bit position: counts 0..2*AW-1, then wraps.
    always_ff @(posedge clk) begin
        if (!rst_n || !part_rst_n) begin
            bit_cnt <= '0;
        end else if (ser_we) begin
            bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
        end
    end

    genvar r, b;
    generate
        for (r = 0; r < NREG; r++) begin : g_reg
            // Decode whether a parallel write targets this register.
            always_comb begin
                reg_par_hit[r] = par_we && (int'(wr_sel) == r);
            end

            for (b = 0; b < AW; b++) begin : g_bit
                // Decode whether the serial stream is at this bit of this register.
                always_comb begin
                    reg_bit_hit[r][b] = ser_we && (bit_cnt == CW'(r * AW + b));
                end
            end

            // Offset storage: reset default, parallel word, or single serial bit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ofs_q[r] <= dflt_ofs;
                end else if (reg_par_hit[r]) begin
                    ofs_q[r] <= wr_val;
                end else if (|reg_bit_hit[r]) begin
                    ofs_q[r] <= (ofs_q[r] & ~reg_bit_hit[r]) | ({AW{ser_in}} & reg_bit_hit[r]);
                end
            end
        end
    endgenerate

    // Map the register array to named outputs.
    always_comb begin
        empty_ofs = ofs_q[SEL_EMPTY];
        full_ofs  = ofs_q[SEL_FULL];
    end

endmodule

// File: rtl/flag_ofs_reader.sv
// Module: flag_ofs_reader
// Returns the offsets on the read path, alternating empty -> full, one per strobed read.
// Assumes: the offsets are zero-extended (or truncated) to DW bits.
module flag_ofs_reader
    import flag_ofs_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          part_rst_n,
    input  logic          ofs_access,
    input  logic          rd_en,
    input  logic [AW-1:0] empty_ofs,
    input  logic [AW-1:0] full_ofs,
    output logic [DW-1:0] rdata,
    output logic          rdata_valid
);

    ofs_sel_e      rd_sel;
    logic          rd_go;
    logic [AW-1:0] rd_pick;

    // Qualified read strobe and selected source value.
    always_comb begin
        rd_go   = part_rst_n && ofs_access && rd_en;
        rd_pick = (rd_sel == SEL_FULL) ? full_ofs : empty_ofs;
    end

    // Read-sequence selector: restarts at the empty offset on any reset.
    always_ff @(posedge clk) begin
        if (!rst_n || !part_rst_n) begin
            rd_sel <= SEL_EMPTY;
        end else if (rd_go) begin
            rd_sel <= next_sel(rd_sel);
        end
    end

    // Output register: cleared by master reset and held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_go) begin
            rdata <= DW'(rd_pick);
        end
    end

    // Valid pulse: high only for the cycle after a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_valid <= 1'b0;
        end else begin
            rdata_valid <= rd_go;
        end
    end

endmodule

// File: rtl/flag_ofs_prog.sv
// Module: flag_ofs_prog (top)
// Programmable flag offset register unit: it latches the method and defaults at
// master reset, programs the offsets serially or in parallel, and reads them back.
// Assumes: a single clock for writes and reads; both resets are synchronous, active low.
module flag_ofs_prog #(
    parameter int AW     = 10,
    parameter int DW     = 18,
    parameter int DEF_LO = 127,
    parameter int DEF_HI = 1023
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          part_rst_n,
    input  logic          ofs_access,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          ser_en,
    input  logic          ser_in,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          rdata_valid,
    output logic [AW-1:0] empty_ofs,
    output logic [AW-1:0] full_ofs,
    output logic          serial_mode
);

    logic [AW-1:0] dflt_ofs;

    flag_ofs_mode #(
        .AW     (AW),
        .DEF_LO (DEF_LO),
        .DEF_HI (DEF_HI)
    ) u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .ofs_access  (ofs_access),
        .serial_mode (serial_mode),
        .dflt_ofs    (dflt_ofs)
    );

    flag_ofs_writer #(
        .AW (AW),
        .DW (DW)
    ) u_writer (
        .clk         (clk),
        .rst_n       (rst_n),
        .part_rst_n  (part_rst_n),
        .dflt_ofs    (dflt_ofs),
        .serial_mode (serial_mode),
        .ofs_access  (ofs_access),
        .wr_en       (wr_en),
        .wdata       (wdata),
        .ser_en      (ser_en),
        .ser_in      (ser_in),
        .empty_ofs   (empty_ofs),
        .full_ofs    (full_ofs)
    );

    flag_ofs_reader #(
        .AW (AW),
        .DW (DW)
    ) u_reader (
        .clk         (clk),
        .rst_n       (rst_n),
        .part_rst_n  (part_rst_n),
        .ofs_access  (ofs_access),
        .rd_en       (rd_en),
        .empty_ofs   (empty_ofs),
        .full_ofs    (full_ofs),
        .rdata       (rdata),
        .rdata_valid (rdata_valid)
    );

endmodule

// File: rtl/flag_ofs_prog_chk.sv
// Module: flag_ofs_prog_chk
// Property checker for flag_ofs_prog, attached through bind.
// Assumes: master reset is held on the first clock edge.
module flag_ofs_prog_chk #(
    parameter int AW     = 10,
    parameter int DW     = 18,
    parameter int DEF_LO = 127,
    parameter int DEF_HI = 1023
) (
    input logic          clk,
    input logic          rst_n,
    input logic          part_rst_n,
    input logic          ofs_access,
    input logic          wr_en,
    input logic          rd_en,
    input logic          ser_en,
    input logic [DW-1:0] rdata,
    input logic          rdata_valid,
    input logic [AW-1:0] empty_ofs,
    input logic [AW-1:0] full_ofs,
    input logic          serial_mode
);

    localparam logic [AW-1:0] LO_VAL = AW'(DEF_LO);
    localparam logic [AW-1:0] HI_VAL = AW'(DEF_HI);

    logic armed = 1'b0;

    // Marks cycles whose previous edge was outside master reset.
    always_ff @(posedge clk) begin
        armed <= rst_n;
    end

    // R1 R2
    default_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (empty_ofs == full_ofs) &&
                   (empty_ofs == (serial_mode ? HI_VAL : LO_VAL)) &&
                   !rdata_valid && (rdata == '0));

    // R2
    mode_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> $stable(serial_mode));

    // R4
    no_unstrobed_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !$past(ofs_access && wr_en) && !$past(serial_mode && ser_en)
        |-> $stable(empty_ofs) && $stable(full_ofs));

    // R6
    parallel_ignores_serial_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !serial_mode && !$past(ofs_access && wr_en)
        |-> $stable(empty_ofs) && $stable(full_ofs));

    // R5
    one_bit_per_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && serial_mode
        |-> $countones({empty_ofs, full_ofs} ^ $past({empty_ofs, full_ofs})) <= 1);

    // R7
    read_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !$past(ofs_access && rd_en && part_rst_n)
        |-> !rdata_valid && $stable(rdata));

    // R8
    partial_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !$past(part_rst_n)
        |-> $stable(empty_ofs) && $stable(full_ofs) && $stable(rdata) && !rdata_valid);

    // R7
    read_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |-> (rdata == DW'(rdata[AW-1:0])));

endmodule

bind flag_ofs_prog flag_ofs_prog_chk #(
    .AW     (AW),
    .DW     (DW),
    .DEF_LO (DEF_LO),
    .DEF_HI (DEF_HI)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .part_rst_n  (part_rst_n),
    .ofs_access  (ofs_access),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .ser_en      (ser_en),
    .rdata       (rdata),
    .rdata_valid (rdata_valid),
    .empty_ofs   (empty_ofs),
    .full_ofs    (full_ofs),
    .serial_mode (serial_mode)
);

// File: tb/flag_ofs_prog_test.sv
// Bench for flag_ofs_prog: a behavioural reference model compared on every clock.
module flag_ofs_prog_test;

    localparam int AW   = 10;
    localparam int DW   = 18;
    localparam int MASK = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          part_rst_n = 1'b1;
    logic          ofs_access = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic          ser_en = 1'b0;
    logic          ser_in = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdata_valid;
    logic [AW-1:0] empty_ofs;
    logic [AW-1:0] full_ofs;
    logic          serial_mode;

    int n_chk = 0;
    int n_fail = 0;
    bit primed = 0;
    string tag = "R1";

    // Reference model state
    int m_emp, m_ful, m_mode, m_wsel, m_rsel, m_bc, m_rdat, m_rval;

    flag_ofs_prog uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .part_rst_n  (part_rst_n),
        .ofs_access  (ofs_access),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .ser_en      (ser_en),
        .ser_in      (ser_in),
        .wdata       (wdata),
        .rdata       (rdata),
        .rdata_valid (rdata_valid),
        .empty_ofs   (empty_ofs),
        .full_ofs    (full_ofs),
        .serial_mode (serial_mode)
    );

    always #5 clk = ~clk;

    task automatic check(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("empty_ofs", int'(empty_ofs), m_emp);
        check("full_ofs", int'(full_ofs), m_ful);
        check("serial_mode", int'(serial_mode), m_mode);
        check("rdata", int'(rdata), m_rdat);
        check("rdata_valid", int'(rdata_valid), m_rval);
    endtask

    // One clock: check the previous edge's result, drive new inputs, advance the model.
    task automatic cyc(input bit r, input bit p, input bit a, input bit w, input bit rd,
                       input bit se, input bit s, input int d);
        int rd_val;
        @(negedge clk);
        if (primed) compare_all();
        rst_n = r; part_rst_n = p; ofs_access = a; wr_en = w; rd_en = rd;
        ser_en = se; ser_in = s; wdata = DW'(d);
        if (!r) begin
            m_emp = a ? (1023 & MASK) : 127;
            m_ful = m_emp;
            m_mode = a; m_wsel = 0; m_rsel = 0; m_bc = 0;
            m_rdat = 0; m_rval = 0;
            primed = 1;
        end else if (!p) begin
            m_wsel = 0; m_rsel = 0; m_bc = 0; m_rval = 0;
        end else begin
            m_rval = 0;
            if (a && rd) begin
                rd_val = m_rsel ? m_ful : m_emp;
                m_rdat = rd_val; m_rval = 1; m_rsel ^= 1;
            end
            if (!m_mode && a && w) begin
                if (m_wsel == 0) m_emp = d & MASK; else m_ful = d & MASK;
                m_wsel ^= 1;
            end
            if (m_mode && se) begin
                if (m_bc < AW) m_emp = (m_emp & ~(1 << m_bc)) | (int'(s) << m_bc);
                else m_ful = (m_ful & ~(1 << (m_bc - AW))) | (int'(s) << (m_bc - AW));
                m_bc = (m_bc + 1) % (2 * AW);
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1, 1, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        bit [15:0] lf;
        // R1: master reset with the access pin low
        tag = "R1";
        cyc(0, 1, 0, 0, 0, 0, 0, 0);
        cyc(0, 1, 0, 1, 1, 1, 1, 0);
        idle(2);
        // R3: parallel writes alternate empty then full, upper bits truncated
        tag = "R3";
        cyc(1, 1, 1, 1, 0, 0, 0, 5);
        cyc(1, 1, 1, 1, 0, 0, 0, 300);
        cyc(1, 1, 1, 1, 0, 0, 0, 'h3FC05);
        cyc(1, 1, 1, 1, 0, 0, 0, 'h2ABCD);
        idle(1);
        // R4: write enable without the strobe, strobe without write enable
        tag = "R4";
        cyc(1, 1, 0, 1, 0, 0, 0, 77);
        cyc(1, 1, 1, 0, 0, 0, 0, 88);
        idle(1);
        // R6: serial enable ignored in parallel mode
        tag = "R6";
        for (int i = 0; i < 6; i++) cyc(1, 1, 0, 0, 0, 1, i[0], 0);
        // R7: alternating read-back, hold, read during write
        tag = "R7";
        cyc(1, 1, 1, 0, 1, 0, 0, 0);
        cyc(1, 1, 1, 0, 1, 0, 0, 0);
        idle(2);
        cyc(1, 1, 1, 1, 1, 0, 0, 999);
        cyc(1, 1, 0, 0, 1, 0, 0, 0);
        idle(1);
        // R8: partial reset keeps offsets and restarts sequences
        tag = "R8";
        cyc(1, 1, 1, 1, 1, 0, 0, 11);
        cyc(1, 0, 1, 1, 1, 0, 0, 22);
        cyc(1, 1, 1, 1, 0, 0, 0, 33);
        cyc(1, 1, 1, 0, 1, 0, 0, 0);
        idle(1);
        // R2: master reset with the access pin high selects serial and 1023
        tag = "R2";
        cyc(0, 1, 1, 0, 0, 0, 0, 0);
        cyc(1, 1, 0, 0, 0, 0, 0, 0);
        idle(2);
        // R4: parallel writes ignored in serial mode
        tag = "R4";
        cyc(1, 1, 1, 1, 0, 0, 0, 5);
        cyc(1, 1, 1, 1, 0, 0, 0, 6);
        idle(1);
        // R5: serial stream, LSB first, gaps with the enable low, then wrap
        tag = "R5";
        for (int i = 0; i < 2 * AW + 4; i++) begin
            cyc(1, 1, 0, 0, 0, 1, (i % 3) == 0, 0);
            if (i % 5 == 4) cyc(1, 1, 0, 0, 0, 0, 1, 0);
        end
        tag = "R7";
        cyc(1, 1, 1, 0, 1, 0, 0, 0);
        cyc(1, 1, 1, 0, 1, 0, 0, 0);
        // R8: partial reset mid-stream restarts at empty bit 0
        tag = "R8";
        for (int i = 0; i < 3; i++) cyc(1, 1, 0, 0, 0, 1, 0, 0);
        cyc(1, 0, 0, 0, 0, 1, 1, 0);
        for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0, 0, 1, 1, 0);
        idle(1);
        // Mixed stimulus in both modes
        tag = "R5";
        lf = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (i == 300) tag = "R3";
            if (i % 150 == 0) cyc(0, 1, lf[3], 0, 0, 0, 0, 0);
            else cyc(1, lf[15:12] != 0, lf[0], lf[1], lf[2], lf[4], lf[5], int'({lf, lf[1:0]}));
        end
        idle(1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule